// File: doc/BRIEF.md
# Asynchronous SAR Conversion Controller

This block sequences a successive-approximation conversion for a differential capacitor DAC. It is built as a chain of per-bit stages. A sample clock holds every stage in reset while the input is being acquired. When that clock drops, the most significant stage arms. Each stage waits for a comparator decision, then waits for the comparator to be cleared. It then freezes its bottom-plate controls and passes its enable to the next lower stage. The comparator clock is regenerated from the stages' handshake loop rather than from a bit counter. A comparison therefore starts as soon as the previous one has been released.

The self-timed ripple is modelled on a fast system clock, and the comparator handshake is sampled on that clock. For every bit the stage drives four bottom-plate lines. Each side of the differential array has a line that only rises (lift) and a line that only falls (drop). The upper NSPLIT stages use split monotonic switching: both sides move, which keeps the common mode near its sampled value. The lower stages use plain monotonic switching, where only one side moves. A result register gathers the decisions, a done flag marks the end of the ripple, and a watchdog flags a comparator that never resolves.

Each stage runs a four-state machine, and all transitions are synchronous to `clk`:
- S_IDLE moves to S_DECIDE on the arm transition, when enable-in is high.
- S_DECIDE moves to S_RELEASE on the decide transition, when a valid decision is seen. The plate update and the decision are captured on this transition.
- S_RELEASE moves to S_HELD on the release transition, when both comparator outputs are low. S_HELD drives enable-out.
- Every state returns to S_IDLE on the flush transition, taken while the sample clock is high.

The loop output of a stage is high only in S_RELEASE.

Top module: `sar_ripple_ctrl`

## Requirements
- R1: While `samp_clk` is high, within one clock edge every bit reads pos_lift=0, pos_drop=1, neg_drop=1, neg_lift=0. In the same time `done` is 0 and `cmp_clk` is 1.
- R2: After `samp_clk` falls, comparisons are assigned to stages strictly from bit NBITS-1 (MSB) down to bit 0. The k-th valid decision (k from 0) belongs to bit NBITS-1-k.
- R3: A valid decision is exactly one of `cmp_p`/`cmp_n` high. When both are high, no plate line changes and the stage does not advance.
- R4: `cmp_clk` is low exactly while a stage is in S_RELEASE, `samp_clk` is low and bit 0 is not held. It returns high one edge after both comparator outputs read 0, which gives exactly NBITS low pulses per conversion.
- R5: For bits at index NBITS-NSPLIT and above (split switching), a P win clears pos_drop and sets neg_lift. An N win sets pos_lift and clears neg_drop.
- R6: For bits below NBITS-NSPLIT (monotonic switching), a P win clears only pos_drop and an N win clears only neg_drop. pos_lift and neg_lift stay 0.
- R7: `result[i]` is 1 when P won bit i. It is captured when stage i enters S_HELD, holds while `samp_clk` stays low, and clears on the rising edge of `samp_clk`.
- R8: `done` rises one edge after bit 0 enters S_HELD. It stays high until `samp_clk` is seen high.
- R9: `cmp_timeout` sets after TMO_CYC consecutive edges with a stage in S_DECIDE and no valid decision. It stays set until `samp_clk` is seen high.
- R10: While `samp_clk` stays low, pos_drop and neg_drop bits only fall and pos_lift and neg_lift bits only rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the handshake |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_clk | input | 1 | Sample clock; high acquires the input and resets the chain |
| cmp_p | input | 1 | Comparator output, positive side won |
| cmp_n | input | 1 | Comparator output, negative side won |
| cmp_clk | output | 1 | Comparator clock; low resets the comparator |
| pos_lift | output | NBITS | Positive-side lines that switch ground to reference |
| pos_drop | output | NBITS | Positive-side lines that switch reference to ground |
| neg_drop | output | NBITS | Negative-side lines that switch reference to ground |
| neg_lift | output | NBITS | Negative-side lines that switch ground to reference |
| result | output | NBITS | Conversion result, bit i = decision of stage i |
| done | output | 1 | Conversion complete |
| cmp_timeout | output | 1 | Comparator failed to resolve in time |

## Verification
The bench builds the block with NBITS=9 and NSPLIT=5, so both switching schemes are present. It uses TMO_CYC=12, which is short enough to reach the watchdog quickly, and a behavioural comparator that answers two cycles after its clock rises. With nine bits, all 512 result codes can be swept exhaustively, and each one is checked against final plate states computed arithmetically from the code. The watchdog threshold is checked at the exact edge where it fires. Forced both-high comparator outputs on the MSB are used to confirm that an invalid decision leaves the chain untouched.

// File: rtl/sar_ripple_pkg.sv
package sar_ripple_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_DECIDE  = 2'd1,
        S_RELEASE = 2'd2,
        S_HELD    = 2'd3
    } stage_state_e;

    typedef struct packed {
        logic pos_lift;
        logic pos_drop;
        logic neg_drop;
        logic neg_lift;
    } plate_t;

    localparam plate_t PLATE_RST = '{pos_lift: 1'b0, pos_drop: 1'b1,
                                     neg_drop: 1'b1, neg_lift: 1'b0};

    function automatic plate_t next_plate(input plate_t cur,
                                          input logic   p_wins,
                                          input logic   split);
        plate_t nxt;
        nxt = cur;
        if (p_wins) begin
            nxt.pos_drop = 1'b0;
            if (split) nxt.neg_lift = 1'b1;
        end else begin
            nxt.neg_drop = 1'b0;
            if (split) nxt.pos_lift = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/sar_bit_stage.sv
module sar_bit_stage
    import sar_ripple_pkg::*;
#(
    parameter bit SPLIT = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   samp_clk,
    input  logic   en_in,
    input  logic   cmp_p,
    input  logic   cmp_n,
    output logic   en_out,
    output logic   loop_out,
    output logic   deciding,
    output logic   win_p,
    output plate_t plate
);

    stage_state_e state_q;
    stage_state_e state_d;
    logic         valid_dec;

    assign valid_dec = cmp_p ^ cmp_n;

    // next-state: arm, decide, release, flush
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (en_in)             state_d = S_DECIDE;
            S_DECIDE:  if (valid_dec)         state_d = S_RELEASE;
            S_RELEASE: if (!cmp_p && !cmp_n) state_d = S_HELD;
            S_HELD:                           state_d = S_HELD;
        endcase
        if (samp_clk) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // decoded handshake outputs
    always_comb begin
        en_out   = 1'b0;
        loop_out = 1'b0;
        deciding = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_DECIDE:  deciding = 1'b1;
            S_RELEASE: loop_out = 1'b1;
            S_HELD:    en_out   = 1'b1;
        endcase
    end

    // plate controls: updated on the decide transition, frozen otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plate <= PLATE_RST;
            win_p <= 1'b0;
        end else if (samp_clk) begin
            plate <= PLATE_RST;
            win_p <= 1'b0;
        end else if (state_q == S_DECIDE && valid_dec) begin
            plate <= next_plate(plate, cmp_p, SPLIT);
            win_p <= cmp_p;
        end
    end

endmodule

// File: rtl/sar_cmp_clock.sv
module sar_cmp_clock #(
    parameter int NBITS   = 9,
    parameter int TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_clk,
    input  logic             cmp_p,
    input  logic             cmp_n,
    input  logic [NBITS-1:0] loop_vec,
    input  logic [NBITS-1:0] deciding_vec,
    input  logic             lsb_held,
    output logic             cmp_clk,
    output logic             cmp_timeout
);

    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] wait_cnt;
    logic          stalled;

    // comparator held in reset while any stage loop is high during conversion
    assign cmp_clk = ~((|loop_vec) & ~samp_clk & ~lsb_held);
    assign stalled = (|deciding_vec) & ~(cmp_p ^ cmp_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt    <= '0;
            cmp_timeout <= 1'b0;
        end else if (samp_clk) begin
            wait_cnt    <= '0;
            cmp_timeout <= 1'b0;
        end else if (stalled) begin
            if (wait_cnt == CW'(TMO_CYC - 1)) cmp_timeout <= 1'b1;
            else                              wait_cnt    <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

endmodule

// File: rtl/sar_result_capture.sv
module sar_result_capture #(
    parameter int NBITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_clk,
    input  logic [NBITS-1:0] held_vec,
    input  logic [NBITS-1:0] win_vec,
    output logic [NBITS-1:0] result,
    output logic             done
);

    logic             samp_q;
    logic [NBITS-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            held_q <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            samp_q <= samp_clk;
            held_q <= held_vec;
            if (samp_clk && !samp_q) begin
                result <= '0;
            end else begin
                for (int i = 0; i < NBITS; i++) begin
                    if (held_vec[i] && !held_q[i]) result[i] <= win_vec[i];
                end
            end
            if (samp_clk)                       done <= 1'b0;
            else if (held_vec[0] && !held_q[0]) done <= 1'b1;
        end
    end

endmodule

// File: rtl/sar_ripple_ctrl.sv
module sar_ripple_ctrl
    import sar_ripple_pkg::*;
#(
    parameter int NBITS   = 9,
    parameter int NSPLIT  = 5,
    parameter int TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_clk,
    input  logic             cmp_p,
    input  logic             cmp_n,
    output logic             cmp_clk,
    output logic [NBITS-1:0] pos_lift,
    output logic [NBITS-1:0] pos_drop,
    output logic [NBITS-1:0] neg_drop,
    output logic [NBITS-1:0] neg_lift,
    output logic [NBITS-1:0] result,
    output logic             done,
    output logic             cmp_timeout
);

    localparam int SPLIT_LO = NBITS - NSPLIT;

    logic [NBITS-1:0] en_vec;
    logic [NBITS-1:0] held_vec;
    logic [NBITS-1:0] loop_vec;
    logic [NBITS-1:0] deciding_vec;
    logic [NBITS-1:0] win_vec;
    plate_t           plate_vec [NBITS];

    for (genvar g = 0; g < NBITS; g++) begin : g_stage
        localparam bit IS_SPLIT = (g >= SPLIT_LO);

        if (g == NBITS - 1) begin : g_head
            assign en_vec[g] = ~samp_clk;
        end else begin : g_link
            assign en_vec[g] = held_vec[g+1];
        end

        sar_bit_stage #(
            .SPLIT(IS_SPLIT)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .samp_clk (samp_clk),
            .en_in    (en_vec[g]),
            .cmp_p    (cmp_p),
            .cmp_n    (cmp_n),
            .en_out   (held_vec[g]),
            .loop_out (loop_vec[g]),
            .deciding (deciding_vec[g]),
            .win_p    (win_vec[g]),
            .plate    (plate_vec[g])
        );

        assign pos_lift[g] = plate_vec[g].pos_lift;
        assign pos_drop[g] = plate_vec[g].pos_drop;
        assign neg_drop[g] = plate_vec[g].neg_drop;
        assign neg_lift[g] = plate_vec[g].neg_lift;
    end

    sar_cmp_clock #(
        .NBITS   (NBITS),
        .TMO_CYC (TMO_CYC)
    ) u_cmp_clock (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_clk     (samp_clk),
        .cmp_p        (cmp_p),
        .cmp_n        (cmp_n),
        .loop_vec     (loop_vec),
        .deciding_vec (deciding_vec),
        .lsb_held     (held_vec[0]),
        .cmp_clk      (cmp_clk),
        .cmp_timeout  (cmp_timeout)
    );

    sar_result_capture #(
        .NBITS (NBITS)
    ) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_clk (samp_clk),
        .held_vec (held_vec),
        .win_vec  (win_vec),
        .result   (result),
        .done     (done)
    );

endmodule

// File: rtl/sar_ripple_checker.sv
module sar_ripple_checker #(
    parameter int NBITS = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_clk,
    input logic             cmp_p,
    input logic             cmp_n,
    input logic             cmp_clk,
    input logic [NBITS-1:0] pos_lift,
    input logic [NBITS-1:0] pos_drop,
    input logic [NBITS-1:0] neg_drop,
    input logic [NBITS-1:0] neg_lift,
    input logic [NBITS-1:0] result,
    input logic             done,
    input logic             cmp_timeout
);

    a_r1_reset_plates: assert property (@(posedge clk) disable iff (!rst_n)
        samp_clk |=> (pos_lift == '0 && pos_drop == '1 &&
                      neg_drop == '1 && neg_lift == '0 && !done));

    a_r3_both_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_clk && cmp_p && cmp_n) |=>
            ($stable(pos_lift) && $stable(pos_drop) &&
             $stable(neg_drop) && $stable(neg_lift)));

    a_r4_release_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_clk && !cmp_p && !cmp_n) |=> cmp_clk);

    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !samp_clk) |=> $stable(result));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !samp_clk) |=> done);

    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_timeout && !samp_clk) |=> cmp_timeout);

    a_r10_one_way_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_clk |=> ((pos_drop & ~$past(pos_drop)) == '0 &&
                       (neg_drop & ~$past(neg_drop)) == '0 &&
                       (~pos_lift & $past(pos_lift)) == '0 &&
                       (~neg_lift & $past(neg_lift)) == '0));

endmodule

bind sar_ripple_ctrl sar_ripple_checker #(.NBITS(NBITS)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_clk    (samp_clk),
    .cmp_p       (cmp_p),
    .cmp_n       (cmp_n),
    .cmp_clk     (cmp_clk),
    .pos_lift    (pos_lift),
    .pos_drop    (pos_drop),
    .neg_drop    (neg_drop),
    .neg_lift    (neg_lift),
    .result      (result),
    .done        (done),
    .cmp_timeout (cmp_timeout)
);

// File: tb/sar_ripple_ctrl_bench.sv
`timescale 1ns/1ps
module sar_ripple_ctrl_bench;

    localparam int NB  = 9;
    localparam int NSP = 5;
    localparam int TMO = 12;
    localparam int DLY = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          samp_clk;
    logic          cmp_p;
    logic          cmp_n;
    logic          cmp_clk;
    logic [NB-1:0] pos_lift, pos_drop, neg_drop, neg_lift, result;
    logic          done, cmp_timeout;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    sar_ripple_ctrl #(.NBITS(NB), .NSPLIT(NSP), .TMO_CYC(TMO)) u_sar_ripple_ctrl (
        .clk(clk), .rst_n(rst_n), .samp_clk(samp_clk), .cmp_p(cmp_p), .cmp_n(cmp_n),
        .cmp_clk(cmp_clk), .pos_lift(pos_lift), .pos_drop(pos_drop),
        .neg_drop(neg_drop), .neg_lift(neg_lift), .result(result),
        .done(done), .cmp_timeout(cmp_timeout)
    );

    // behavioural comparator: answers DLY cycles after its clock is high
    int            idx = NB - 1;
    int            dcnt = 0;
    int            both_left = 0;
    bit            given = 1'b0;
    bit            mute = 1'b0;
    logic [NB-1:0] code_r = '0;

    always @(negedge clk) begin
        if (samp_clk) begin
            idx = NB - 1; given = 1'b0; dcnt = 0;
            cmp_p <= 1'b0; cmp_n <= 1'b0;
        end else if (!cmp_clk) begin
            cmp_p <= 1'b0; cmp_n <= 1'b0; dcnt = 0;
            if (given) begin given = 1'b0; idx = idx - 1; end
        end else if (!given && idx >= 0) begin
            if (dcnt < DLY) dcnt++;
            else if (!mute) begin
                if (both_left > 0) begin
                    cmp_p <= 1'b1; cmp_n <= 1'b1; both_left--;
                end else begin
                    cmp_p <= code_r[idx]; cmp_n <= ~code_r[idx]; given = 1'b1;
                end
            end
        end
    end

    // monitor: comparator clock pulses (R4) and line direction (R10)
    logic          prev_cc = 1'b1;
    logic          prev_samp = 1'b1;
    logic [NB-1:0] pv_pl = '0, pv_pd = '1, pv_nd = '1, pv_nl = '0;
    int            falls = 0;
    int            wrong_way = 0;

    always @(negedge clk) begin
        if (samp_clk) falls = 0;
        else if (prev_cc && !cmp_clk) falls++;
        if (rst_n && !samp_clk && !prev_samp) begin
            if ((pos_drop & ~pv_pd) != '0 || (neg_drop & ~pv_nd) != '0 ||
                (~pos_lift & pv_pl) != '0 || (~neg_lift & pv_nl) != '0)
                wrong_way++;
        end
        prev_cc = cmp_clk; prev_samp = samp_clk;
        pv_pl = pos_lift; pv_pd = pos_drop; pv_nd = neg_drop; pv_nl = neg_lift;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // expected final plate vector; which: 0 pos_lift, 1 pos_drop, 2 neg_drop, 3 neg_lift
    function automatic logic [NB-1:0] exp_lines(input logic [NB-1:0] c, input int which);
        logic [NB-1:0] v;
        for (int k = 0; k < NB; k++) begin
            bit split = (k >= NB - NSP);
            unique case (which)
                0: v[k] = split & ~c[k];
                1: v[k] = ~c[k];
                2: v[k] = c[k];
                default: v[k] = split & c[k];
            endcase
        end
        return v;
    endfunction

    task automatic check_reset_state(input string tag);
        chk(pos_lift == '0 && neg_lift == '0, tag, int'(pos_lift | neg_lift), 0);
        chk(pos_drop == '1 && neg_drop == '1, tag, int'(pos_drop & neg_drop), (1 << NB) - 1);
        chk(!done && cmp_clk, tag, int'({done, cmp_clk}), 1);
    endtask

    task automatic start_conv(input logic [NB-1:0] c, input int both, input bit mute_it);
        samp_clk = 1'b1; code_r = c; both_left = both; mute = mute_it;
        tick(); tick();
        samp_clk = 1'b0;
    endtask

    task automatic finish_conv(input logic [NB-1:0] c, input bit full);
        int n = 0;
        while (!done && n < 400) begin tick(); n++; end
        chk(done, "R8 done reached", int'(done), 1);
        chk(result == c, "R2 R7 result", int'(result), int'(c));
        chk(falls == NB, "R4 comparator clock pulses", falls, NB);
        chk({pos_lift, neg_lift} == {exp_lines(c, 0), exp_lines(c, 3)},
            "R5 split lines", int'({pos_lift, neg_lift}), int'({exp_lines(c, 0), exp_lines(c, 3)}));
        chk({pos_drop, neg_drop} == {exp_lines(c, 1), exp_lines(c, 2)},
            "R6 drop lines", int'({pos_drop, neg_drop}), int'({exp_lines(c, 1), exp_lines(c, 2)}));
        if (full) begin
            repeat (5) tick();
            chk(done, "R8 done holds", int'(done), 1);
            chk(result == c, "R7 result holds", int'(result), int'(c));
            samp_clk = 1'b1;
            tick();
            chk(result == '0, "R7 result cleared on sample rise", int'(result), 0);
            check_reset_state("R1 after sample rise");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; samp_clk = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick(); tick();
        check_reset_state("R1 reset state");
        chk(result == '0 && !cmp_timeout, "R1 reset result", int'(result), 0);

        // first conversion with early done check and hold checks
        start_conv(9'h1B3, 0, 1'b0);
        tick();
        chk(!done, "R8 done low early", int'(done), 0);
        finish_conv(9'h1B3, 1'b1);

        // both-high on MSB must not count as a decision
        start_conv(9'h0A5, 3, 1'b0);
        begin
            int n = 0;
            while (!(cmp_p && cmp_n) && n < 20) begin tick(); n++; end
        end
        tick();
        chk(cmp_clk == 1'b1, "R3 no advance on both high", int'(cmp_clk), 1);
        chk(pos_drop == '1 && neg_drop == '1, "R3 lines untouched", int'(pos_drop & neg_drop), (1 << NB) - 1);
        finish_conv(9'h0A5, 1'b0);
        chk(!cmp_timeout, "R9 no false timeout", int'(cmp_timeout), 0);
        start_conv(9'h15A, 3, 1'b0);
        finish_conv(9'h15A, 1'b0);

        // watchdog threshold
        start_conv(9'h0F0, 0, 1'b1);
        repeat (TMO) @(posedge clk);
        tick();
        chk(!cmp_timeout, "R9 not yet timed out", int'(cmp_timeout), 0);
        @(posedge clk);
        tick();
        chk(cmp_timeout, "R9 timeout fires", int'(cmp_timeout), 1);
        mute = 1'b0;
        finish_conv(9'h0F0, 1'b0);
        chk(cmp_timeout, "R9 timeout sticky", int'(cmp_timeout), 1);
        samp_clk = 1'b1;
        tick();
        chk(!cmp_timeout, "R9 timeout clears", int'(cmp_timeout), 0);

        // exhaustive sweep of all codes
        for (int c = 0; c < (1 << NB); c++) begin
            start_conv(NB'(c), 0, 1'b0);
            finish_conv(NB'(c), (c % 64) == 0);
        end
        chk(wrong_way == 0, "R10 one-way line motion", wrong_way, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule